// File: doc/BRIEF.md
# Shared-Line Interrupt Delivery Engine

This block sits between the interrupt sources of a chip and the interrupt controllers of its cores. It follows the electrical state of a set of input lines, each of which may be driven by several sources at once, and turns each new assertion into a delivery message. The routing for every line comes from a 64-bit redirection entry that another block stores and decodes. This engine only reads that entry. It owns two things of its own: a remote-pending flag per line for level-triggered lines, and an assertion count per line.

Sources issue one command per cycle: raise, lower, or pulse a line. The engine adds up the raises and lowers per line in a small saturating signed counter. A message is queued only when a count steps from zero to one. Two other inputs can also cause a delivery. An end-of-interrupt input carries a vector and re-arms, and possibly re-sends, the level-triggered lines that were waiting on that vector. A write-triggered request asks for one line to be re-evaluated after its entry was rewritten. Queued deliveries leave one at a time over a valid/ready message port.

Top module: `intr_delivery_engine`

## Requirements
- R1: Each line holds a 4-bit signed count. A raise adds one and a lower subtracts one. The count saturates at +7 and at -8 and never wraps.
- R2: A delivery is queued only when a command moves a count from 0 to 1. A move from 1 to 0, or any other change, queues nothing.
- R3: A pulse command (cmdOp 2) behaves as a raise followed at once by a lower on the same line. It therefore delivers when the count was 0 and leaves the count unchanged. A raise is cmdOp 0 and a lower is cmdOp 1.
- R4: A command that leaves a count below zero sets negError. negError stays set until reset.
- R5: A command whose line number is NUM_PINS or above, or whose cmdOp is 3, changes no count and queues nothing. It raises cmdReject for the cycle after it.
- R6: A line whose entry has bit 16 (mask) set never queues a delivery, whatever the path.
- R7: When a delivery is queued for a line whose entry has bit 15 set (level), that line's remoteIrr bit is set. Lines with bit 15 clear never set it.
- R8: A message carries the following fields. The vector is entry bits 7:0. The delivery mode is bits 10:8. msgPhysical is the inverse of bit 11. The destination is bits 63:56. msgLevel is bit 15.
- R9: An end-of-interrupt clears remoteIrr on every line whose remoteIrr is set and whose vector equals eoiVector. Each such line with a count above zero is delivered again.
- R10: A 0-to-1 count change delivers even while the line's remoteIrr is set.
- R11: A write-triggered request for a line delivers only if the line is unmasked, its remoteIrr is clear, and its count is above zero.
- R12: Queued deliveries leave one at a time, lowest line number first. A message stays valid until msgReady is seen. A line that is queued again in its grant cycle stays queued.
- R13: After reset all counts are zero and nothing is queued. remoteIrr, negError and cmdReject are all clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Line command present this cycle |
| cmdOp | input | 2 | 0 raise, 1 lower, 2 pulse, 3 reserved |
| cmdPin | input | 6 | Line number of the command |
| cmdReject | output | 1 | Previous command was refused |
| eoiValid | input | 1 | End-of-interrupt present this cycle |
| eoiVector | input | 8 | Vector being retired |
| wrValid | input | 1 | Write-triggered re-evaluation request |
| wrPin | input | 6 | Line to re-evaluate |
| redirTable | input | 2048 | Redirection entries, 64 bits per line, line 0 lowest |
| msgValid | output | 1 | Message available |
| msgReady | input | 1 | Consumer takes the message |
| msgVector | output | 8 | Message vector |
| msgDest | output | 8 | Message destination |
| msgPhysical | output | 1 | Physical destination mode |
| msgMode | output | 3 | Delivery mode |
| msgLevel | output | 1 | Level-triggered message |
| remoteIrr | output | 32 | Per-line remote-pending flags |
| negError | output | 1 | Sticky negative-count flag |

## Verification
The case where two delivery causes land on the same clock edge is the one that matters most. In the bench, an end-of-interrupt that re-sends the level line arrives in the same cycle as a fresh raise on a lower-numbered edge line. Both lines must be queued on that one edge. The test judges this by the order in which the messages drain (the lower line first) and by the routing fields of each message. The write-triggered path and the raise path are exercised against an already set remoteIrr, to show that only the first of them checks it.

// File: rtl/iee_pkg.sv
package iee_pkg;
  localparam int ENTRY_W      = 64;
  localparam int VEC_LSB      = 0;
  localparam int VEC_W        = 8;
  localparam int MODE_LSB     = 8;
  localparam int MODE_W       = 3;
  localparam int DESTMODE_BIT = 11;
  localparam int TRIG_BIT     = 15;
  localparam int MASK_BIT     = 16;
  localparam int DEST_LSB     = 56;
  localparam int DEST_W       = 8;

  typedef enum logic [1:0] {
    OP_RAISE = 2'd0,
    OP_LOWER = 2'd1,
    OP_PULSE = 2'd2,
    OP_RSVD  = 2'd3
  } pin_op_e;

  // per-line strobes from the count datapath to the delivery control
  typedef struct packed {
    logic rise;  // count steps 0 -> 1 this cycle
    logic live;  // registered count above zero
  } pin_strobe_t;
endpackage

// File: rtl/iee_count_bank.sv
module iee_count_bank
  import iee_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 4,
  parameter int PIN_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [PIN_W-1:0]  cmdPin,
  output pin_strobe_t       strb [NUM_PINS],
  output logic              cmdReject,
  output logic              negError
);
  localparam logic [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PIN_W-1:0] PIN_LIMIT = PIN_W'(NUM_PINS);

  function automatic logic [CNT_W-1:0] satUp(input logic [CNT_W-1:0] c);
    return (c == CMAX) ? c : c + ONE;
  endfunction

  function automatic logic [CNT_W-1:0] satDown(input logic [CNT_W-1:0] c);
    return (c == CMIN) ? c : c - ONE;
  endfunction

  pin_op_e opE;
  logic    cmdOk;
  logic [NUM_PINS-1:0] negHit;

  assign opE   = pin_op_e'(cmdOp);
  assign cmdOk = cmdValid && (cmdPin < PIN_LIMIT) && (opE != OP_RSVD);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_line
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic             hit;

    assign hit = cmdOk && (cmdPin == PIN_W'(i));

    always_comb begin
      unique case (opE)
        OP_RAISE: nxt = satUp(cnt);
        OP_LOWER: nxt = satDown(cnt);
        OP_PULSE: nxt = satDown(satUp(cnt));
        default:  nxt = cnt;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN)    cnt <= '0;
      else if (hit) cnt <= nxt;
    end

    assign strb[i].rise = hit && (cnt == '0) && (opE == OP_RAISE || opE == OP_PULSE);
    assign strb[i].live = !cnt[CNT_W-1] && (cnt != '0);
    assign negHit[i]    = hit && nxt[CNT_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReject <= 1'b0;
      negError  <= 1'b0;
    end else begin
      cmdReject <= cmdValid && !cmdOk;
      if (|negHit) negError <= 1'b1;
    end
  end
endmodule

// File: rtl/iee_deliver_ctrl.sv
module iee_deliver_ctrl
  import iee_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pin_strobe_t                  strb [NUM_PINS],
  input  logic [NUM_PINS*ENTRY_W-1:0]  redirTable,
  input  logic                         eoiValid,
  input  logic [VEC_W-1:0]             eoiVector,
  input  logic                         wrValid,
  input  logic [PIN_W-1:0]             wrPin,
  input  logic                         msgReady,
  output logic                         msgValid,
  output logic [VEC_W-1:0]             msgVector,
  output logic [DEST_W-1:0]            msgDest,
  output logic                         msgPhysical,
  output logic [MODE_W-1:0]            msgMode,
  output logic                         msgLevel,
  output logic [NUM_PINS-1:0]          remoteIrr
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [ENTRY_W-1:0]  entryArr [NUM_PINS];
  logic [NUM_PINS-1:0] fire, levelFire, eoiClr, pending, grantOh, grant;
  logic [IDX_W-1:0]    selIdx;
  logic [ENTRY_W-1:0]  selEntry;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_line
    logic masked, lvl, wrHit;
    assign entryArr[i] = redirTable[i*ENTRY_W +: ENTRY_W];
    assign masked      = entryArr[i][MASK_BIT];
    assign lvl         = entryArr[i][TRIG_BIT];
    assign eoiClr[i]   = eoiValid && remoteIrr[i] &&
                         (entryArr[i][VEC_LSB +: VEC_W] == eoiVector);
    assign wrHit       = wrValid && (wrPin == PIN_W'(i)) && !remoteIrr[i] && strb[i].live;
    assign fire[i]     = !masked && (strb[i].rise || (eoiClr[i] && strb[i].live) || wrHit);
    assign levelFire[i] = fire[i] && lvl;
  end

  // lowest queued line wins
  assign grantOh = pending & (~pending + 1'b1);
  assign msgValid = |pending;
  assign grant    = (msgValid && msgReady) ? grantOh : '0;

  always_comb begin
    selIdx = '0;
    for (int k = NUM_PINS - 1; k >= 0; k--) begin
      if (pending[k]) selIdx = IDX_W'(k);
    end
  end

  assign selEntry    = entryArr[selIdx];
  assign msgVector   = selEntry[VEC_LSB +: VEC_W];
  assign msgDest     = selEntry[DEST_LSB +: DEST_W];
  assign msgPhysical = !selEntry[DESTMODE_BIT];
  assign msgMode     = selEntry[MODE_LSB +: MODE_W];
  assign msgLevel    = selEntry[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= '0;
      remoteIrr <= '0;
    end else begin
      pending   <= (pending & ~grant) | fire;
      remoteIrr <= (remoteIrr & ~eoiClr) | levelFire;
    end
  end
endmodule

// File: rtl/intr_delivery_engine.sv
module intr_delivery_engine
  import iee_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 4,
  parameter int PIN_W    = $clog2(NUM_PINS) + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  input  logic [1:0]                   cmdOp,
  input  logic [PIN_W-1:0]             cmdPin,
  output logic                         cmdReject,
  input  logic                         eoiValid,
  input  logic [7:0]                   eoiVector,
  input  logic                         wrValid,
  input  logic [PIN_W-1:0]             wrPin,
  input  logic [NUM_PINS*64-1:0]       redirTable,
  output logic                         msgValid,
  input  logic                         msgReady,
  output logic [7:0]                   msgVector,
  output logic [7:0]                   msgDest,
  output logic                         msgPhysical,
  output logic [2:0]                   msgMode,
  output logic                         msgLevel,
  output logic [NUM_PINS-1:0]          remoteIrr,
  output logic                         negError
);
  pin_strobe_t strb [NUM_PINS];

  iee_count_bank #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .PIN_W(PIN_W)) u_count (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPin(cmdPin),
    .strb(strb), .cmdReject(cmdReject), .negError(negError)
  );

  iee_deliver_ctrl #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .strb(strb), .redirTable(redirTable),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .wrValid(wrValid), .wrPin(wrPin),
    .msgReady(msgReady), .msgValid(msgValid), .msgVector(msgVector), .msgDest(msgDest),
    .msgPhysical(msgPhysical), .msgMode(msgMode), .msgLevel(msgLevel),
    .remoteIrr(remoteIrr)
  );
endmodule

// File: rtl/iee_checker.sv
module iee_checker #(
  parameter int NUM_PINS = 32,
  parameter int PIN_W    = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [PIN_W-1:0]    cmdPin,
  input logic                cmdReject,
  input logic                eoiValid,
  input logic                wrValid,
  input logic                msgValid,
  input logic                msgReady,
  input logic [NUM_PINS-1:0] remoteIrr,
  input logic                negError
);
  localparam logic [PIN_W-1:0] PIN_LIMIT = PIN_W'(NUM_PINS);

  // R12
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid);

  // R5
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> $past(cmdValid));

  // R5
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdPin >= PIN_LIMIT) && !eoiValid && !wrValid && !msgValid |=> !msgValid);

  // R4
  neg_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    negError |=> negError);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_irr
    // R7
    irr_queued_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(remoteIrr[i]) |-> msgValid);
  end
endmodule

bind intr_delivery_engine iee_checker #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_iee_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPin(cmdPin), .cmdReject(cmdReject),
  .eoiValid(eoiValid), .wrValid(wrValid), .msgValid(msgValid), .msgReady(msgReady),
  .remoteIrr(remoteIrr), .negError(negError)
);

// File: tb/intr_delivery_engine_bench.sv
`timescale 1ns/1ps
module intr_delivery_engine_bench;
  localparam int NUM_PINS = 32;
  localparam int PIN_W    = 6;
  localparam int LVL_PIN  = 5;
  localparam int MSK_PIN  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [PIN_W-1:0] cmdPin = '0;
  logic cmdReject;
  logic eoiValid = 1'b0;
  logic [7:0] eoiVector = 8'd0;
  logic wrValid = 1'b0;
  logic [PIN_W-1:0] wrPin = '0;
  logic [NUM_PINS*64-1:0] redirTable;
  logic msgValid;
  logic msgReady = 1'b0;
  logic [7:0] msgVector, msgDest;
  logic msgPhysical, msgLevel;
  logic [2:0] msgMode;
  logic [NUM_PINS-1:0] remoteIrr;
  logic negError;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  intr_delivery_engine u_intr_delivery_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPin(cmdPin),
    .cmdReject(cmdReject), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .wrValid(wrValid), .wrPin(wrPin), .redirTable(redirTable),
    .msgValid(msgValid), .msgReady(msgReady), .msgVector(msgVector), .msgDest(msgDest),
    .msgPhysical(msgPhysical), .msgMode(msgMode), .msgLevel(msgLevel),
    .remoteIrr(remoteIrr), .negError(negError)
  );

  function automatic logic [7:0] vecOf(input int p);
    return 8'(8'h20 + p);
  endfunction

  // entry layout per R8, mask R6, level R7
  function automatic logic [63:0] entryOf(input int p);
    logic [63:0] e = '0;
    e[7:0]   = vecOf(p);
    e[10:8]  = 3'(p % 8);
    e[11]    = p[0];
    e[15]    = (p == LVL_PIN);
    e[16]    = (p == MSK_PIN);
    e[63:56] = 8'(p * 3 + 1);
    return e;
  endfunction

  function automatic logic [20:0] expFields(input int p);
    return {vecOf(p), 8'(p * 3 + 1), ~p[0], 3'(p % 8), 1'(p == LVL_PIN)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int p);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdPin = PIN_W'(p);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic sendEoi(input logic [7:0] v);
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = v;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  task automatic sendWr(input int p);
    @(negedge clk);
    wrValid = 1'b1; wrPin = PIN_W'(p);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
  endtask

  task automatic expectMsg(input int p, input string req);
    logic [20:0] act;
    act = {msgVector, msgDest, msgPhysical, msgMode, msgLevel};
    check(msgValid === 1'b1, req, 64'(msgValid), 64'd1);
    check(act === expFields(p), req, 64'(act), 64'(expFields(p)));
    pop();
  endtask

  task automatic expectNone(input string req);
    check(msgValid === 1'b0, req, 64'(msgValid), 64'd0);
  endtask

  // rows: op[15:14] pin[13:8] expect-message[7]
  localparam logic [15:0] ROWS [8] = '{
    {2'd0, 6'd3, 1'b1, 7'd0},   // R2 0->1 delivers
    {2'd0, 6'd3, 1'b0, 7'd0},   // R1 1->2 silent
    {2'd1, 6'd3, 1'b0, 7'd0},   // R1 2->1 silent
    {2'd1, 6'd3, 1'b0, 7'd0},   // R2 1->0 silent
    {2'd2, 6'd3, 1'b1, 7'd0},   // R3 pulse from 0 delivers
    {2'd0, 6'd5, 1'b1, 7'd0},   // R7 level line delivers
    {2'd1, 6'd5, 1'b0, 7'd0},   // R2 1->0 silent
    {2'd0, 6'd5, 1'b1, 7'd0}    // R10 delivers with remoteIrr set
  };

  initial begin
    for (int p = 0; p < NUM_PINS; p++) redirTable[p*64 +: 64] = entryOf(p);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R13 reset state
    check(msgValid === 1'b0 && remoteIrr === '0 && negError === 1'b0 && cmdReject === 1'b0,
          "R13", 64'({msgValid, negError, cmdReject, remoteIrr}), 64'd0);

    for (int r = 0; r < 8; r++) begin
      logic [15:0] row;
      row = ROWS[r];
      issue(row[15:14], int'(row[13:8]));
      if (row[7]) expectMsg(int'(row[13:8]), "R2");
      else        expectNone("R2");
    end
    check(remoteIrr[LVL_PIN] === 1'b1, "R7", 64'(remoteIrr[LVL_PIN]), 64'd1);
    check(remoteIrr[3] === 1'b0, "R7", 64'(remoteIrr[3]), 64'd0);

    // R9 wrong vector: flag kept, nothing sent
    sendEoi(8'hEE);
    expectNone("R9");
    check(remoteIrr[LVL_PIN] === 1'b1, "R9", 64'(remoteIrr[LVL_PIN]), 64'd1);

    // R9 + R12: EOI re-delivers line 5 in the same cycle as a fresh raise on line 2
    @(negedge clk);
    eoiValid = 1'b1; eoiVector = vecOf(LVL_PIN);
    cmdValid = 1'b1; cmdOp = 2'd0; cmdPin = PIN_W'(2);
    @(negedge clk);
    eoiValid = 1'b0; cmdValid = 1'b0;
    expectMsg(2, "R12");
    expectMsg(LVL_PIN, "R9");
    expectNone("R12");
    check(remoteIrr[LVL_PIN] === 1'b1, "R9", 64'(remoteIrr[LVL_PIN]), 64'd1);

    // R12 message held while not ready
    issue(2'd0, 9);
    repeat (3) @(negedge clk);
    expectMsg(9, "R12");
    issue(2'd1, 9);

    // R9 count now zero: EOI clears without sending
    issue(2'd1, LVL_PIN);
    sendEoi(vecOf(LVL_PIN));
    expectNone("R9");
    check(remoteIrr[LVL_PIN] === 1'b0, "R9", 64'(remoteIrr[LVL_PIN]), 64'd0);

    // R11 write path
    sendWr(LVL_PIN);
    expectNone("R11");
    issue(2'd0, LVL_PIN);
    expectMsg(LVL_PIN, "R11");
    sendWr(LVL_PIN);
    expectNone("R11");
    sendWr(3);
    expectNone("R11");
    issue(2'd0, 3);
    expectMsg(3, "R11");
    sendWr(3);
    expectMsg(3, "R11");

    // R6 masked line
    issue(2'd0, MSK_PIN);
    expectNone("R6");
    sendWr(MSK_PIN);
    expectNone("R6");

    // R5 out-of-range line and reserved op
    issue(2'd0, 40);
    check(cmdReject === 1'b1, "R5", 64'(cmdReject), 64'd1);
    expectNone("R5");
    issue(2'd0, 8);
    expectMsg(8, "R5");
    issue(2'd3, 12);
    check(cmdReject === 1'b1, "R5", 64'(cmdReject), 64'd1);
    issue(2'd0, 12);
    check(cmdReject === 1'b0, "R5", 64'(cmdReject), 64'd0);
    expectMsg(12, "R5");

    // R4 negative count
    check(negError === 1'b0, "R4", 64'(negError), 64'd0);
    issue(2'd1, 10);
    check(negError === 1'b1, "R4", 64'(negError), 64'd1);
    issue(2'd0, 10);
    expectNone("R4");
    issue(2'd0, 10);
    expectMsg(10, "R4");
    check(negError === 1'b1, "R4", 64'(negError), 64'd1);

    // R1 saturation at +7
    issue(2'd0, 11);
    expectMsg(11, "R1");
    for (int k = 0; k < 8; k++) issue(2'd0, 11);
    for (int k = 0; k < 7; k++) issue(2'd1, 11);
    expectNone("R1");
    issue(2'd0, 11);
    expectMsg(11, "R1");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL R13 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule